// File: doc/BRIEF.md
# Link Exchange State Machine

This block governs when a serial point-to-point link may carry traffic. It decides, cycle by cycle, whether the transmitter is silent, sending NULL characters only, sending NULL and flow-control (FCT) characters, or free to move data, and whether the receiver is listening. It takes a start request, an auto-start mode bit, character-arrival strobes from the receiver (NULL, FCT, any other character) and three receiver error strobes (parity, disconnect, escape sequence).

Any error seen while the receiver is listening sends the block straight back to its reset state. The transmitter goes quiet at once, so the far end loses signal, records a disconnect and goes quiet in turn. Both ends then follow a fixed, timed recovery. The block holds everything off for a short interval. It then listens with the transmitter still silent for a longer interval and waits in a ready state for permission. After that it sends NULLs until it has heard a NULL, and then sends FCTs until it has heard an FCT. Only then does it raise the running flag. If the handshake stalls at either stage, a timeout restarts the recovery. All intervals are given in nanoseconds and turned into clock cycles from the clock frequency parameter.

Top module: `lx_link_ctrl`

## Requirements
- R1: While reset is asserted the state output reads 0 (silent reset) and tx_en, tx_fct_en, tx_data_en, rx_en and running are all 0. The state codes are 0 silent reset, 1 listen-wait, 2 ready, 3 sending NULLs, 4 sending FCTs, 5 running.
- R2: The silent reset state (0) keeps tx_en and rx_en low for exactly RESET_NS worth of cycles and then moves to state 1.
- R3: State 1 has rx_en high and tx_en low. With no fault it lasts exactly WAIT_NS worth of cycles and then moves to state 2.
- R4: State 2 keeps the transmitter off and holds while start_req and auto_start are both low. One cycle with start_req high moves it to state 3. With auto_start high it spends a single cycle in state 2.
- R5: State 3 has tx_en high and tx_fct_en low. A received NULL moves it to state 4 on the next cycle.
- R6: State 4 has tx_fct_en high and tx_data_en low. A received FCT moves it to state 5, where running and tx_data_en are high.
- R7: States 3 and 4 each time out after TMO_NS worth of cycles without progress and return to state 0.
- R8: A parity, disconnect or escape error while rx_en is high forces state 0 on the next cycle, with tx_en and rx_en low (silencing the far end).
- R9: An FCT or any non-NULL character received while rx_en is high and before the first NULL since the last entry into state 0 counts as an error and forces state 0.
- R10: Errors and characters that arrive during state 0 are ignored: they neither restart nor lengthen the silent interval.
- R11: A NULL received in state 1 or 2 is remembered, so state 3 moves to state 4 after a single cycle without needing another NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-style reset, sampled on clk |
| start_req | input | 1 | Request to leave the ready state |
| auto_start | input | 1 | Leave the ready state without a request |
| rx_null | input | 1 | Receiver decoded a NULL this cycle |
| rx_fct | input | 1 | Receiver decoded an FCT this cycle |
| rx_char | input | 1 | Receiver decoded any other character this cycle |
| err_par | input | 1 | Receiver parity error strobe |
| err_disc | input | 1 | Receiver disconnect error strobe |
| err_esc | input | 1 | Receiver escape-sequence error strobe |
| tx_en | output | 1 | Transmitter active (NULLs at least) |
| tx_fct_en | output | 1 | Transmitter may send FCTs |
| tx_data_en | output | 1 | Transmitter may send data |
| rx_en | output | 1 | Receiver enabled |
| link_state | output | 3 | Current state code (see R1) |
| running | output | 1 | Link is in the running state |

## Verification
The bound assertions check the local rules on every cycle. An error with the receiver on always lands in silent reset with the transmitter off. Running is only entered from the FCT state on a received FCT, and the FCT state only on a known NULL. Ready holds without permission, listen-wait can exit only to ready or reset, and the handshake states never outlive their timeout. The exact lengths of the silent and listen intervals, the immunity of the silent interval to noise, and the memory of an early NULL are shown only by the bench's scenarios, which count cycles at the ports.

// File: rtl/lx_pkg.sv
package lx_pkg;

  typedef enum logic [2:0] {
    LS_ERR_RESET  = 3'd0,
    LS_ERR_WAIT   = 3'd1,
    LS_READY      = 3'd2,
    LS_STARTED    = 3'd3,
    LS_CONNECTING = 3'd4,
    LS_RUN        = 3'd5
  } lx_state_e;

  // Round an interval in ns up to whole cycles of a clock given in MHz.
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Dwell limit for each state; 0 means the state has no time limit.
  function automatic int dwell_limit(input lx_state_e s, input int rst_c,
                                     input int wait_c, input int tmo_c);
    case (s)
      LS_ERR_RESET:  return rst_c;
      LS_ERR_WAIT:   return wait_c;
      LS_STARTED,
      LS_CONNECTING: return tmo_c;
      default:       return 0;
    endcase
  endfunction

  function automatic logic tx_active(input lx_state_e s);
    return (s == LS_STARTED) || (s == LS_CONNECTING) || (s == LS_RUN);
  endfunction

  function automatic logic fct_allowed(input lx_state_e s);
    return (s == LS_CONNECTING) || (s == LS_RUN);
  endfunction

  function automatic logic rx_active(input lx_state_e s);
    return s != LS_ERR_RESET;
  endfunction

endpackage

// File: rtl/lx_dwell_timer.sv
module lx_dwell_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != {CNT_W{1'b1}}) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Last cycle of the permitted dwell.
  assign expired = (limit != '0) && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/lx_rx_screen.sv
module lx_rx_screen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic rx_null,
  input  logic rx_fct,
  input  logic rx_char,
  input  logic err_par,
  input  logic err_disc,
  input  logic err_esc,
  output logic null_seen_now,
  output logic fct_evt,
  output logic fault
);

  logic null_seen_q;
  logic line_err;
  logic early_char;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      null_seen_q <= 1'b0;
    end else if (!rx_en) begin
      null_seen_q <= 1'b0;
    end else if (rx_null) begin
      null_seen_q <= 1'b1;
    end
  end

  assign null_seen_now = null_seen_q | (rx_en & rx_null);
  assign fct_evt       = rx_en & rx_fct;
  assign line_err      = err_par | err_disc | err_esc;
  assign early_char    = (rx_fct | rx_char) & ~null_seen_q;
  assign fault         = rx_en & (line_err | early_char);

endmodule

// File: rtl/lx_fsm.sv
module lx_fsm
  import lx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_req,
  input  logic      auto_start,
  input  logic      fault,
  input  logic      null_seen_now,
  input  logic      fct_evt,
  input  logic      tmr_expired,
  output lx_state_e state,
  output logic      state_chg
);

  lx_state_e state_nxt;

  always_comb begin
    state_nxt = state;
    case (state)
      LS_ERR_RESET: begin
        if (tmr_expired) state_nxt = LS_ERR_WAIT;
      end
      LS_ERR_WAIT: begin
        if (fault)            state_nxt = LS_ERR_RESET;
        else if (tmr_expired) state_nxt = LS_READY;
      end
      LS_READY: begin
        if (fault)                        state_nxt = LS_ERR_RESET;
        else if (start_req || auto_start) state_nxt = LS_STARTED;
      end
      LS_STARTED: begin
        if (fault || tmr_expired) state_nxt = LS_ERR_RESET;
        else if (null_seen_now)   state_nxt = LS_CONNECTING;
      end
      LS_CONNECTING: begin
        if (fault || tmr_expired) state_nxt = LS_ERR_RESET;
        else if (fct_evt)         state_nxt = LS_RUN;
      end
      LS_RUN: begin
        if (fault) state_nxt = LS_ERR_RESET;
      end
      default: state_nxt = LS_ERR_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= LS_ERR_RESET;
    else        state <= state_nxt;
  end

  assign state_chg = (state_nxt != state);

endmodule

// File: rtl/lx_link_ctrl.sv
module lx_link_ctrl
  import lx_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int RESET_NS = 6400,
  parameter int WAIT_NS  = 12800,
  parameter int TMO_NS   = 12800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       auto_start,
  input  logic       rx_null,
  input  logic       rx_fct,
  input  logic       rx_char,
  input  logic       err_par,
  input  logic       err_disc,
  input  logic       err_esc,
  output logic       tx_en,
  output logic       tx_fct_en,
  output logic       tx_data_en,
  output logic       rx_en,
  output logic [2:0] link_state,
  output logic       running
);

  localparam int RST_C  = ns_to_cycles(RESET_NS, CLK_MHZ);
  localparam int WAIT_C = ns_to_cycles(WAIT_NS, CLK_MHZ);
  localparam int TMO_C  = ns_to_cycles(TMO_NS, CLK_MHZ);
  localparam int MAX_C  = max3(RST_C, WAIT_C, TMO_C);
  localparam int CNT_W  = $clog2(MAX_C + 1);

  lx_state_e        state;
  logic             state_chg;
  logic             tmr_expired;
  logic             fault_w;
  logic             null_seen_now_w;
  logic             fct_evt_w;
  logic [CNT_W-1:0] limit_w;

  assign limit_w = CNT_W'(dwell_limit(state, RST_C, WAIT_C, TMO_C));
  assign rx_en   = rx_active(state);

  lx_rx_screen u_screen (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .rx_null       (rx_null),
    .rx_fct        (rx_fct),
    .rx_char       (rx_char),
    .err_par       (err_par),
    .err_disc      (err_disc),
    .err_esc       (err_esc),
    .null_seen_now (null_seen_now_w),
    .fct_evt       (fct_evt_w),
    .fault         (fault_w)
  );

  lx_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_chg),
    .limit   (limit_w),
    .expired (tmr_expired)
  );

  lx_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_req     (start_req),
    .auto_start    (auto_start),
    .fault         (fault_w),
    .null_seen_now (null_seen_now_w),
    .fct_evt       (fct_evt_w),
    .tmr_expired   (tmr_expired),
    .state         (state),
    .state_chg     (state_chg)
  );

  assign tx_en      = tx_active(state);
  assign tx_fct_en  = fct_allowed(state);
  assign tx_data_en = (state == LS_RUN);
  assign running    = (state == LS_RUN);
  assign link_state = state;

endmodule

// File: rtl/lx_link_ctrl_chk.sv
module lx_link_ctrl_chk #(
  parameter int TMO_C = 2560
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       auto_start,
  input logic       rx_fct,
  input logic       rx_char,
  input logic       err_par,
  input logic       err_disc,
  input logic       err_esc,
  input logic       tx_en,
  input logic       rx_en,
  input logic [2:0] link_state,
  input logic       running,
  input logic       fault_w,
  input logic       null_seen_now_w
);

  logic [2:0]  prev_q;
  logic [15:0] held_q;

  // Cycles the previous state has been held, counted independently.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 3'd0;
      held_q <= 16'd0;
    end else begin
      prev_q <= link_state;
      if (link_state != prev_q)   held_q <= 16'd1;
      else if (held_q != 16'hFFFF) held_q <= held_q + 16'd1;
    end
  end

  p_silence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && (err_par || err_disc || err_esc)) |=> (link_state == 3'd0 && !tx_en));

  p_early_char_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !null_seen_now_w && (rx_fct || rx_char)) |=> (link_state == 3'd0));

  p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd2 && !start_req && !auto_start && !fault_w) |=> (link_state == 3'd2));

  p_conn_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_state == 3'd4 && $past(link_state) != 3'd4) |-> $past(null_seen_now_w));

  p_run_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(rx_fct) && $past(link_state) == 3'd4));

  p_wait_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(link_state) == 3'd1 && link_state != 3'd1) |-> (link_state == 3'd2 || link_state == 3'd0));

  p_handshake_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_q == 3'd3 || prev_q == 3'd4) |-> (int'(held_q) <= TMO_C));

endmodule

bind lx_link_ctrl lx_link_ctrl_chk #(.TMO_C(TMO_C)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_req       (start_req),
  .auto_start      (auto_start),
  .rx_fct          (rx_fct),
  .rx_char         (rx_char),
  .err_par         (err_par),
  .err_disc        (err_disc),
  .err_esc         (err_esc),
  .tx_en           (tx_en),
  .rx_en           (rx_en),
  .link_state      (link_state),
  .running         (running),
  .fault_w         (fault_w),
  .null_seen_now_w (null_seen_now_w)
);

// File: tb/tb_lx_link_ctrl.sv
module tb_lx_link_ctrl;

  localparam int MHZ    = 200;
  localparam int R_NS   = 30;  // 6 cycles
  localparam int W_NS   = 50;  // 10 cycles
  localparam int T_NS   = 70;  // 14 cycles
  localparam int EXP_R  = 6;
  localparam int EXP_W  = 10;
  localparam int EXP_T  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 0, auto_start = 0, rx_null = 0, rx_fct = 0, rx_char = 0;
  logic err_par = 0, err_disc = 0, err_esc = 0;
  logic tx_en, tx_fct_en, tx_data_en, rx_en, running;
  logic [2:0] link_state;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lx_link_ctrl #(.CLK_MHZ(MHZ), .RESET_NS(R_NS), .WAIT_NS(W_NS), .TMO_NS(T_NS)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .auto_start(auto_start),
    .rx_null(rx_null), .rx_fct(rx_fct), .rx_char(rx_char),
    .err_par(err_par), .err_disc(err_disc), .err_esc(err_esc),
    .tx_en(tx_en), .tx_fct_en(tx_fct_en), .tx_data_en(tx_data_en),
    .rx_en(rx_en), .link_state(link_state), .running(running)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Drive one input high for one cycle; returns at the negedge where its effect shows.
  task automatic pulse(input string which);
    case (which)
      "start": start_req = 1;
      "null":  rx_null   = 1;
      "fct":   rx_fct    = 1;
      "char":  rx_char   = 1;
      "par":   err_par   = 1;
      "disc":  err_disc  = 1;
      "esc":   err_esc   = 1;
      default: ;
    endcase
    step();
    {start_req, rx_null, rx_fct, rx_char, err_par, err_disc, err_esc} = '0;
  endtask

  task automatic wait_state(input int s, input string req);
    int n = 0;
    while (int'(link_state) != s && n < 200) begin
      step();
      n++;
    end
    chk(req, "reached state", int'(link_state), s);
  endtask

  task automatic dwell(input int s, output int n);
    n = 0;
    while (int'(link_state) == s && n < 500) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) step();
    chk("R1", "state in reset", int'(link_state), 0);
    chk("R1", "tx_en in reset", int'(tx_en), 0);
    chk("R1", "rx_en in reset", int'(rx_en), 0);
    chk("R1", "running in reset", int'(running), 0);
    chk("R1", "fct/data in reset", int'({tx_fct_en, tx_data_en}), 0);
    rst_n = 1;
  endtask

  task automatic t_bringup();
    int n;
    wait_state(1, "R3");
    chk("R3", "rx_en in wait", int'(rx_en), 1);
    chk("R3", "tx_en in wait", int'(tx_en), 0);
    dwell(1, n);
    chk("R3", "wait dwell", n, EXP_W);
    chk("R3", "after wait", int'(link_state), 2);
    for (int i = 0; i < 5; i++) step();
    chk("R4", "ready holds", int'(link_state), 2);
    chk("R4", "tx off in ready", int'(tx_en), 0);
    pulse("start");
    chk("R5", "state after start", int'(link_state), 3);
    chk("R5", "tx_en sending nulls", int'(tx_en), 1);
    chk("R5", "no fct yet", int'(tx_fct_en), 0);
    for (int i = 0; i < 3; i++) step();
    chk("R5", "started holds without null", int'(link_state), 3);
    pulse("null");
    chk("R5", "state after null", int'(link_state), 4);
    chk("R6", "fct allowed", int'(tx_fct_en), 1);
    chk("R6", "no data yet", int'(tx_data_en), 0);
    pulse("fct");
    chk("R6", "state after fct", int'(link_state), 5);
    chk("R6", "running", int'(running), 1);
    chk("R6", "data allowed", int'(tx_data_en), 1);
  endtask

  task automatic t_run_error();
    int n;
    pulse("par");
    chk("R8", "state after parity err", int'(link_state), 0);
    chk("R8", "tx silenced", int'(tx_en), 0);
    chk("R8", "rx off", int'(rx_en), 0);
    dwell(0, n);
    chk("R2", "silent reset dwell", n, EXP_R);
    chk("R2", "after silent reset", int'(link_state), 1);
  endtask

  task automatic t_noise_in_reset();
    int n;
    pulse("disc");
    chk("R8", "disconnect in wait", int'(link_state), 0);
    {err_esc, err_par, rx_fct, rx_char} = '1;
    step();
    chk("R10", "noise ignored 1", int'(link_state), 0);
    step();
    {err_esc, err_par, rx_fct, rx_char} = '0;
    chk("R10", "noise ignored 2", int'(link_state), 0);
    dwell(0, n);
    chk("R10", "silent dwell unchanged", n + 2, EXP_R);
    chk("R10", "reaches wait", int'(link_state), 1);
  endtask

  task automatic t_timeout_started();
    int n;
    wait_state(2, "R7");
    pulse("start");
    chk("R7", "in started", int'(link_state), 3);
    dwell(3, n);
    chk("R7", "started timeout", n, EXP_T);
    chk("R7", "back to reset", int'(link_state), 0);
  endtask

  task automatic t_auto_and_conn_timeout();
    int n;
    auto_start = 1;
    wait_state(2, "R4");
    dwell(2, n);
    chk("R4", "auto ready dwell", n, 1);
    chk("R4", "auto leaves ready", int'(link_state), 3);
    pulse("esc");
    chk("R8", "escape err in started", int'(link_state), 0);
    wait_state(3, "R4");
    pulse("null");
    chk("R5", "connecting", int'(link_state), 4);
    dwell(4, n);
    chk("R7", "connecting timeout", n, EXP_T);
    chk("R7", "back to reset", int'(link_state), 0);
    auto_start = 0;
  endtask

  task automatic t_early_chars();
    wait_state(1, "R9");
    pulse("fct");
    chk("R9", "fct before null in wait", int'(link_state), 0);
    wait_state(2, "R9");
    pulse("char");
    chk("R9", "char before null in ready", int'(link_state), 0);
  endtask

  task automatic t_null_memory();
    wait_state(1, "R11");
    pulse("null");
    chk("R11", "null in wait keeps wait", int'(link_state), 1);
    wait_state(2, "R11");
    pulse("start");
    chk("R11", "started entered", int'(link_state), 3);
    step();
    chk("R11", "remembered null", int'(link_state), 4);
    pulse("fct");
    chk("R6", "run after remembered null", int'(running), 1);
    pulse("char");
    chk("R6", "data char in run ok", int'(link_state), 5);
  endtask

  initial begin
    step();
    t_reset();
    t_bringup();
    t_run_error();
    t_noise_in_reset();
    t_timeout_started();
    t_auto_and_conn_timeout();
    t_early_chars();
    t_null_memory();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule